// File: doc/BRIEF.md
# Integer Accumulator Arithmetic-Logic Stage

This block is the integer datapath of a byte-commanded accumulator coprocessor. Each command carries the current accumulator value, an operand and a 5-bit operation code. The operand is either a register value or a literal count taken from the command byte. The command also carries the incoming carry and overflow flags. One clock edge later the block presents the new accumulator value and the zero, negative, overflow and carry flags.

The carry follows the convention of classic 8-bit processors. For addition it is the carry out. For subtraction it means "no borrow occurred", so subtract-with-borrow consumes the inverted carry. The block provides:

- a compare that changes only the flags;
- separate signed and unsigned minimum and maximum;
- logical and arithmetic shifts and a left rotate, each with a count taken modulo the word width.

Multiply, divide and remainder are handled by a separate unit. The block has no state machine: its only state is one output register stage, loaded on every accepted command and held otherwise.

Top module: `accalu_core`

## Requirements
- R1: Operation codes on `op_i` are ADD=0, ADC=1, SUB=2, SBC=3, RSB=4, CMP=5, NEG=6, ABS=7, AND=8, OR=9, XOR=10, SHL=11, SHR=12, SAR=13, ROL=14, MINU=15, MINS=16, MAXU=17, MAXS=18, SETC=19. For an assigned code with `valid_i` high, the result appears on the outputs on the next rising edge and `valid_o` is high for one cycle.
- R2: If `valid_i` is low or the code is unassigned (20 to 31), `valid_o` is low in the next cycle and `acc_o` and all flags keep their values.
- R3: ADD gives A+B and ADC gives A+B+C. C is the carry out of the top bit. V is set on signed overflow.
- R4: SUB gives A−B, SBC gives A−B−(1−C), and RSB gives B−A. C is 1 when no borrow occurs. V is set on signed overflow.
- R5: CMP sets Z, N, V and C exactly as SUB would, and `acc_o` equals the incoming A.
- R6: NEG gives 0−A, with C=1 only when A is 0. ABS gives |A| and leaves C unchanged. For both, A=0x80000000 yields 0x80000000 and sets V; any other A clears V.
- R7: AND, OR and XOR give the bitwise result and leave C and V unchanged.
- R8: SHL, SHR (zero fill) and SAR (sign fill) shift by `opd_i[4:0]`, so the count is taken modulo 32. For a nonzero count, C is the last bit shifted out. V is unchanged.
- R9: ROL rotates left by `opd_i[4:0]`. For a nonzero count, C equals bit 0 of the result. V is unchanged.
- R10: For any shift or rotate with a count of 0, A and C are unchanged.
- R11: MINU and MAXU compare unsigned, and MINS and MAXS compare signed. C and V are unchanged.
- R12: SETC loads C from `opd_i[0]` only. A and V are unchanged.
- R13: For every assigned code, Z is set when the result is zero and N equals its top bit. For CMP the result is the difference; for SETC it is A.
- R14: While `rst_n` is low, `valid_o`, `acc_o` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Command present this cycle |
| op_i | input | 5 | Operation code |
| acc_i | input | 32 | Current accumulator value A |
| opd_i | input | 32 | Operand B, or a count in its low 5 bits |
| c_i | input | 1 | Incoming carry flag |
| v_i | input | 1 | Incoming overflow flag |
| valid_o | output | 1 | Result valid |
| acc_o | output | 32 | New accumulator value |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |

## Verification
The assertions check the following rules on every accepted command:

- idle cycles and unassigned codes hold the outputs;
- compare leaves A alone;
- logic operations keep C and V;
- a zero shift count changes neither A nor C;
- set-carry takes bit 0 only;
- an unsigned minimum never exceeds either input.

Exact arithmetic is checked only by the bench's directed scenarios. This covers carry and overflow at the word boundaries, the inverted-borrow convention, the single unrepresentable magnitude for negate and absolute value, the last-bit-out carry, a count wrapping modulo 32, and the signed-versus-unsigned ordering of the same pair.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_RSB  = 5'd4,
        OP_CMP  = 5'd5,
        OP_NEG  = 5'd6,
        OP_ABS  = 5'd7,
        OP_AND  = 5'd8,
        OP_OR   = 5'd9,
        OP_XOR  = 5'd10,
        OP_SHL  = 5'd11,
        OP_SHR  = 5'd12,
        OP_SAR  = 5'd13,
        OP_ROL  = 5'd14,
        OP_MINU = 5'd15,
        OP_MINS = 5'd16,
        OP_MAXU = 5'd17,
        OP_MAXS = 5'd18,
        OP_SETC = 5'd19
    } alu_op_e;

    localparam int unsigned LAST_OP = 19;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2,
        SH_ROT   = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/accalu_addsub.sv
module accalu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    // One adder serves every add/subtract form; callers invert y and pick cin.
    always_comb begin
        {cout, sum} = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        ovf = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end
endmodule

// File: rtl/accalu_shift.sv
module accalu_shift
    import accalu_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  a,
    input  logic [CW-1:0] cnt,
    input  shift_kind_e   kind,
    output logic [W-1:0]  res,
    output logic          cout
);
    logic [W:0]     left_w;
    logic [W:0]     right_w;
    logic [W:0]     arith_w;
    logic [2*W-1:0] rot_w;

    // Widened forms keep the last bit out next to the result; the rotate
    // uses a doubled word so a zero count never needs a full-width shift.
    always_comb begin
        left_w  = {1'b0, a} << cnt;
        right_w = {a, 1'b0} >> cnt;
        arith_w = $unsigned($signed({a, 1'b0}) >>> cnt);
        rot_w   = {a, a} << cnt;
        unique case (kind)
            SH_LEFT:  begin res = left_w[W-1:0];  cout = left_w[W];  end
            SH_RIGHT: begin res = right_w[W:1];   cout = right_w[0]; end
            SH_ARITH: begin res = arith_w[W:1];   cout = arith_w[0]; end
            default:  begin res = rot_w[2*W-1:W]; cout = rot_w[W];   end
        endcase
    end
endmodule

// File: rtl/accalu_minmax.sv
module accalu_minmax #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_signed,
    input  logic         take_max,
    output logic [W-1:0] res
);
    logic a_less;

    always_comb begin
        a_less = is_signed ? ($signed(a) < $signed(b)) : (a < b);
        if (take_max) res = a_less ? b : a;
        else          res = a_less ? a : b;
    end
endmodule

// File: rtl/accalu_core.sv
module accalu_core
    import accalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [4:0]   op_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opd_i,
    input  logic         c_i,
    input  logic         v_i,
    output logic         valid_o,
    output logic [W-1:0] acc_o,
    output logic         z_o,
    output logic         n_o,
    output logic         v_o,
    output logic         c_o
);
    localparam int CW = $clog2(W);
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    alu_op_e     op;
    logic        op_known;
    logic [W-1:0] add_x, add_y, add_sum;
    logic        add_cin, add_cout, add_ovf;
    logic [W-1:0] sh_res, mm_res;
    logic        sh_cout;
    shift_kind_e sh_kind;
    logic [CW-1:0] sh_cnt;
    logic [W-1:0] nxt_acc, zn_src;
    alu_flags_t  nxt_f;

    assign op       = alu_op_e'(op_i);
    assign op_known = (32'(op_i) <= LAST_OP);
    assign sh_cnt   = opd_i[CW-1:0];

    // Operand steering for the shared adder
    always_comb begin
        add_x = acc_i; add_y = opd_i; add_cin = 1'b0;
        case (op)
            OP_ADC:                 add_cin = c_i;
            OP_SUB, OP_CMP:  begin  add_y = ~opd_i; add_cin = 1'b1; end
            OP_SBC:          begin  add_y = ~opd_i; add_cin = c_i;  end
            OP_RSB:          begin  add_x = opd_i; add_y = ~acc_i; add_cin = 1'b1; end
            OP_NEG, OP_ABS:  begin  add_x = '0;    add_y = ~acc_i; add_cin = 1'b1; end
            default: ;
        endcase
    end

    always_comb begin
        case (op)
            OP_SHR:  sh_kind = SH_RIGHT;
            OP_SAR:  sh_kind = SH_ARITH;
            OP_ROL:  sh_kind = SH_ROT;
            default: sh_kind = SH_LEFT;
        endcase
    end

    accalu_addsub #(.W(W)) u_add (
        .x(add_x), .y(add_y), .cin(add_cin),
        .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
    );

    accalu_shift #(.W(W), .CW(CW)) u_shift (
        .a(acc_i), .cnt(sh_cnt), .kind(sh_kind), .res(sh_res), .cout(sh_cout)
    );

    accalu_minmax #(.W(W)) u_mm (
        .a(acc_i), .b(opd_i),
        .is_signed(op == OP_MINS || op == OP_MAXS),
        .take_max(op == OP_MAXU || op == OP_MAXS),
        .res(mm_res)
    );

    // Result and flag selection
    always_comb begin
        nxt_acc = acc_i;
        nxt_f.c = c_i;
        nxt_f.v = v_i;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_RSB: begin
                nxt_acc = add_sum; nxt_f.c = add_cout; nxt_f.v = add_ovf;
            end
            OP_CMP: begin
                nxt_f.c = add_cout; nxt_f.v = add_ovf;
            end
            OP_NEG: begin
                nxt_acc = add_sum; nxt_f.c = add_cout; nxt_f.v = (acc_i == MIN_NEG);
            end
            OP_ABS: begin
                nxt_acc = acc_i[W-1] ? add_sum : acc_i; nxt_f.v = (acc_i == MIN_NEG);
            end
            OP_AND: nxt_acc = acc_i & opd_i;
            OP_OR:  nxt_acc = acc_i | opd_i;
            OP_XOR: nxt_acc = acc_i ^ opd_i;
            OP_SHL, OP_SHR, OP_SAR, OP_ROL: begin
                nxt_acc = sh_res;
                if (sh_cnt != '0) nxt_f.c = sh_cout;
            end
            OP_MINU, OP_MINS, OP_MAXU, OP_MAXS: nxt_acc = mm_res;
            OP_SETC: nxt_f.c = opd_i[0];
            default: ;
        endcase
        zn_src  = (op == OP_CMP) ? add_sum : nxt_acc;
        nxt_f.z = (zn_src == '0);
        nxt_f.n = zn_src[W-1];
    end

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            acc_o   <= '0;
            {z_o, n_o, v_o, c_o} <= 4'b0000;
        end else begin
            valid_o <= valid_i && op_known;
            if (valid_i && op_known) begin
                acc_o <= nxt_acc;
                {z_o, n_o, v_o, c_o} <= nxt_f;
            end
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && op_known) |=> !valid_o && $stable(acc_o) && $stable({z_o, n_o, v_o, c_o}));

    // R5
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op == OP_CMP) |=> valid_o && acc_o == $past(acc_i));

    // R7
    logic_keeps_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op == OP_AND || op == OP_OR || op == OP_XOR))
        |=> c_o == $past(c_i) && v_o == $past(v_i));

    // R10
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op == OP_SHL || op == OP_SHR || op == OP_SAR || op == OP_ROL)
         && opd_i[CW-1:0] == '0)
        |=> acc_o == $past(acc_i) && c_o == $past(c_i));

    // R11
    umin_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op == OP_MINU) |=> acc_o <= $past(acc_i) && acc_o <= $past(opd_i));

    // R12
    setc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op == OP_SETC)
        |=> c_o == $past(opd_i[0]) && acc_o == $past(acc_i) && v_o == $past(v_i));

    // R14
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !valid_o && acc_o == '0 && {z_o, n_o, v_o, c_o} == 4'b0000);
endmodule

// File: tb/accalu_core_test.sv
module accalu_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [4:0]  op_i = '0;
    logic [31:0] acc_i = '0;
    logic [31:0] opd_i = '0;
    logic        c_i = 1'b0;
    logic        v_i = 1'b0;
    logic        valid_o;
    logic [31:0] acc_o;
    logic        z_o, n_o, v_o, c_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    accalu_core uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .acc_i(acc_i), .opd_i(opd_i), .c_i(c_i), .v_i(v_i),
        .valid_o(valid_o), .acc_o(acc_o),
        .z_o(z_o), .n_o(n_o), .v_o(v_o), .c_o(c_o)
    );

    // Flag vector order: {Z, N, V, C}
    task automatic chk(input string req, input logic [31:0] ea, input logic [3:0] ef,
                       input logic ev);
        total++;
        if (acc_o !== ea || {z_o, n_o, v_o, c_o} !== ef || valid_o !== ev) begin
            bad++;
            $display("FAIL %s: acc=%h znvc=%b valid=%b expected acc=%h znvc=%b valid=%b",
                     req, acc_o, {z_o, n_o, v_o, c_o}, valid_o, ea, ef, ev);
        end
    endtask

    task automatic run(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic ci, input logic vi, input logic vld);
        @(negedge clk);
        valid_i = vld; op_i = op; acc_i = a; opd_i = b; c_i = ci; v_i = vi;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R14 reset", 32'h0, 4'b0000, 1'b0);
    endtask

    task automatic t_add;
        run(5'd0, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0, 1'b1);
        chk("R3 add wrap", 32'h0, 4'b1001, 1'b1);
        run(5'd0, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b0, 1'b1);
        chk("R3 add ovf R13", 32'h8000_0000, 4'b0110, 1'b1);
        run(5'd1, 32'h5, 32'h3, 1'b1, 1'b0, 1'b1);
        chk("R3 adc R1", 32'h9, 4'b0000, 1'b1);
    endtask

    task automatic t_sub;
        run(5'd2, 32'h5, 32'h3, 1'b0, 1'b0, 1'b1);
        chk("R4 sub", 32'h2, 4'b0001, 1'b1);
        run(5'd2, 32'h3, 32'h5, 1'b1, 1'b0, 1'b1);
        chk("R4 sub borrow", 32'hFFFF_FFFE, 4'b0100, 1'b1);
        run(5'd3, 32'd10, 32'd3, 1'b0, 1'b0, 1'b1);
        chk("R4 sbc", 32'd6, 4'b0001, 1'b1);
        run(5'd3, 32'd10, 32'd3, 1'b1, 1'b0, 1'b1);
        chk("R4 sbc carry set", 32'd7, 4'b0001, 1'b1);
        run(5'd4, 32'd3, 32'd10, 1'b0, 1'b0, 1'b1);
        chk("R4 rsb", 32'd7, 4'b0001, 1'b1);
    endtask

    task automatic t_cmp;
        run(5'd5, 32'd7, 32'd7, 1'b0, 1'b0, 1'b1);
        chk("R5 cmp equal", 32'd7, 4'b1001, 1'b1);
        run(5'd5, 32'd1, 32'd2, 1'b1, 1'b1, 1'b1);
        chk("R5 cmp less R13", 32'd1, 4'b0100, 1'b1);
    endtask

    task automatic t_negabs;
        run(5'd6, 32'd1, 32'd0, 1'b1, 1'b0, 1'b1);
        chk("R6 neg", 32'hFFFF_FFFF, 4'b0100, 1'b1);
        run(5'd6, 32'd0, 32'd0, 1'b0, 1'b1, 1'b1);
        chk("R6 neg zero", 32'd0, 4'b1001, 1'b1);
        run(5'd6, 32'h8000_0000, 32'd0, 1'b0, 1'b0, 1'b1);
        chk("R6 neg min", 32'h8000_0000, 4'b0110, 1'b1);
        run(5'd7, 32'hFFFF_FFFB, 32'd0, 1'b1, 1'b1, 1'b1);
        chk("R6 abs", 32'd5, 4'b0001, 1'b1);
        run(5'd7, 32'h8000_0000, 32'd0, 1'b0, 1'b0, 1'b1);
        chk("R6 abs min", 32'h8000_0000, 4'b0110, 1'b1);
    endtask

    task automatic t_logic;
        run(5'd8, 32'h0000_F0F0, 32'h0000_0FF0, 1'b1, 1'b1, 1'b1);
        chk("R7 and", 32'h0000_00F0, 4'b0011, 1'b1);
        run(5'd9, 32'h8000_0000, 32'h0000_0001, 1'b0, 1'b1, 1'b1);
        chk("R7 or", 32'h8000_0001, 4'b0110, 1'b1);
        run(5'd10, 32'h1234_5678, 32'h1234_5678, 1'b0, 1'b0, 1'b1);
        chk("R7 xor R13", 32'h0, 4'b1000, 1'b1);
    endtask

    task automatic t_shift;
        run(5'd11, 32'h8000_0001, 32'd1, 1'b0, 1'b0, 1'b1);
        chk("R8 shl", 32'h2, 4'b0001, 1'b1);
        run(5'd12, 32'h3, 32'd1, 1'b0, 1'b1, 1'b1);
        chk("R8 shr", 32'h1, 4'b0011, 1'b1);
        run(5'd13, 32'h8000_0000, 32'd4, 1'b1, 1'b0, 1'b1);
        chk("R8 sar", 32'hF800_0000, 4'b0100, 1'b1);
        run(5'd12, 32'h8000_0000, 32'd4, 1'b1, 1'b0, 1'b1);
        chk("R8 shr zero fill", 32'h0800_0000, 4'b0000, 1'b1);
        run(5'd11, 32'h1, 32'd33, 1'b1, 1'b0, 1'b1);
        chk("R8 count mod 32", 32'h2, 4'b0000, 1'b1);
        run(5'd12, 32'd5, 32'd0, 1'b1, 1'b0, 1'b1);
        chk("R10 shr zero", 32'd5, 4'b0001, 1'b1);
        run(5'd11, 32'h8000_0000, 32'd32, 1'b1, 1'b0, 1'b1);
        chk("R10 shl count 32", 32'h8000_0000, 4'b0101, 1'b1);
    endtask

    task automatic t_rotate;
        run(5'd14, 32'h8000_0001, 32'd1, 1'b0, 1'b0, 1'b1);
        chk("R9 rol 1", 32'h3, 4'b0001, 1'b1);
        run(5'd14, 32'h1234_5678, 32'd8, 1'b1, 1'b0, 1'b1);
        chk("R9 rol 8", 32'h3456_7812, 4'b0000, 1'b1);
        run(5'd14, 32'h8000_0000, 32'd0, 1'b0, 1'b0, 1'b1);
        chk("R10 rol zero", 32'h8000_0000, 4'b0100, 1'b1);
    endtask

    task automatic t_minmax;
        run(5'd15, 32'hFFFF_FFFF, 32'd1, 1'b1, 1'b0, 1'b1);
        chk("R11 minu", 32'd1, 4'b0001, 1'b1);
        run(5'd16, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1, 1'b1);
        chk("R11 mins", 32'hFFFF_FFFF, 4'b0110, 1'b1);
        run(5'd17, 32'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1);
        chk("R11 maxu", 32'hFFFF_FFFF, 4'b0100, 1'b1);
        run(5'd18, 32'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1);
        chk("R11 maxs", 32'd1, 4'b0000, 1'b1);
    endtask

    task automatic t_setc;
        run(5'd19, 32'd0, 32'd1, 1'b0, 1'b1, 1'b1);
        chk("R12 setc one", 32'd0, 4'b1011, 1'b1);
        run(5'd19, 32'h8000_0000, 32'hFE, 1'b1, 1'b0, 1'b1);
        chk("R12 setc bit0 only", 32'h8000_0000, 4'b0100, 1'b1);
    endtask

    task automatic t_idle;
        run(5'd2, 32'd9, 32'd4, 1'b0, 1'b0, 1'b1);
        chk("R1 load", 32'd5, 4'b0001, 1'b1);
        run(5'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b0);
        chk("R2 no valid", 32'd5, 4'b0001, 1'b0);
        run(5'd25, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1, 1'b1);
        chk("R2 unassigned code", 32'd5, 4'b0001, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_cmp();
        t_negabs();
        t_logic();
        t_shift();
        t_rotate();
        t_minmax();
        t_setc();
        t_idle();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule